// File: doc/BRIEF.md
# Unaligned Word Store Aligner

This block forms the memory write for the two partial-word store operations that together write a 32-bit register value to an address that is not word aligned. On a little-endian bus, the byte at the lowest address of the aligned word sits in byte lane 0. The block takes three inputs: the kind of store (left or right), the two low bits of the effective address and the source register. It returns a write data word with the register bytes placed in the correct lanes, and a byte-enable mask for the aligned word that holds that address. Lanes whose enable is low must be left untouched by the memory.

A left store writes the upper bytes of the register, starting from the most significant one. It writes them downward from the effective address to the lowest byte of the aligned word. A right store writes the lower bytes of the register, starting from the least significant one. It writes them upward from the effective address to the highest byte of the aligned word. Software stores an unaligned word at address A by issuing a right store at A and a left store at A+3. The block is purely combinational. Address generation and the memory array sit outside it.

Top module: `ua_store_align`

## Requirements
- R1: When `kind_i` is 0 (left store), `be_o` enables lanes 0 through `ofs_i`. For offsets 0, 1, 2 and 3 this gives 0001, 0011, 0111 and 1111.
- R2: When `kind_i` is 1 (right store), `be_o` enables lanes `ofs_i` through 3. For offsets 0, 1, 2 and 3 this gives 1111, 1110, 1100 and 1000.
- R3: A left store places the most significant register byte (bits 31:24) in lane `ofs_i`. Each lower lane down to lane 0 takes the next less significant byte.
- R4: A right store places the least significant register byte (bits 7:0) in lane `ofs_i`. Each higher lane up to lane 3 takes the next more significant byte.
- R5: Every lane of `wdata_o` whose enable bit is low is driven to zero.
- R6: A left store enables `ofs_i`+1 lanes. A right store enables 4-`ofs_i` lanes.
- R7: A left store at offset 3 and a right store at offset 0 both reproduce the register unchanged with all four lanes enabled.
- R8: With a byte-enabled memory, every byte outside the enabled lanes keeps its prior value.
- R9: A right store at address A followed by a left store at address A+3 leaves the four register bytes at A..A+3 in little-endian order.
- R10: The outputs follow the inputs with no clock or register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kind_i | input | 1 | Store kind: 0 left, 1 right |
| ofs_i | input | 2 | Effective address bits 1:0 |
| src_i | input | 32 | Source register value |
| wdata_o | output | 32 | Lane-positioned write data, zero in disabled lanes |
| be_o | output | 4 | Byte enables for the aligned word, bit n for lane n |

## Verification
The two store kinds meet whenever a word crosses an alignment boundary. The right store writes the upper lanes of one aligned word, and the left store writes the lower lanes of the next aligned word. The bench provokes this by issuing both stores at several misaligned addresses into a behavioural byte-enabled memory that was first filled with a known pattern. It then judges the result in two ways. The reassembled register must appear at the target bytes, and every neighbouring byte must still hold the pattern. The full-word case, where either kind alone covers the whole word, is checked for both kinds.

// File: rtl/ua_store_pkg.sv
package ua_store_pkg;
  typedef enum logic {
    KIND_LEFT  = 1'b0,
    KIND_RIGHT = 1'b1
  } store_kind_e;
endpackage

// File: rtl/ua_mask_gen.sv
module ua_mask_gen
  import ua_store_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  localparam int OFS_W = $clog2(WORD_BYTES)
) (
  input  store_kind_e            kind_i,
  input  logic [OFS_W-1:0]       ofs_i,
  output logic [WORD_BYTES-1:0]  be_o
);
  for (genvar j = 0; j < WORD_BYTES; j++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE = OFS_W'(j);
    always_comb begin
      if (kind_i == KIND_LEFT) be_o[j] = (LANE <= ofs_i);
      else                     be_o[j] = (LANE >= ofs_i);
    end
  end
endmodule

// File: rtl/ua_byte_rot.sv
module ua_byte_rot #(
  parameter int WORD_BYTES = 4,
  parameter int BYTE_W     = 8,
  localparam int OFS_W  = $clog2(WORD_BYTES),
  localparam int DATA_W = WORD_BYTES * BYTE_W
) (
  input  logic [OFS_W-1:0]  amt_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] rot_o
);
  // lane j takes source byte (j - amt) mod WORD_BYTES
  for (genvar j = 0; j < WORD_BYTES; j++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE = OFS_W'(j);
    logic [OFS_W-1:0] sel;
    always_comb begin
      sel = LANE - amt_i;
      rot_o[j*BYTE_W +: BYTE_W] = src_i[sel*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/ua_store_align.sv
module ua_store_align
  import ua_store_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int BYTE_W     = 8,
  localparam int OFS_W  = $clog2(WORD_BYTES),
  localparam int DATA_W = WORD_BYTES * BYTE_W
) (
  input  logic                  kind_i,
  input  logic [OFS_W-1:0]      ofs_i,
  input  logic [DATA_W-1:0]     src_i,
  output logic [DATA_W-1:0]     wdata_o,
  output logic [WORD_BYTES-1:0] be_o
);
  store_kind_e      kind;
  logic [OFS_W-1:0] amt;
  logic [DATA_W-1:0] rot;

  assign kind = store_kind_e'(kind_i);
  // left store: top byte lands at ofs, so rotate by ofs+1
  assign amt  = (kind == KIND_LEFT) ? ofs_i + OFS_W'(1) : ofs_i;

  ua_mask_gen #(.WORD_BYTES(WORD_BYTES)) i_mask (
    .kind_i (kind),
    .ofs_i  (ofs_i),
    .be_o   (be_o)
  );

  ua_byte_rot #(.WORD_BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) i_rot (
    .amt_i (amt),
    .src_i (src_i),
    .rot_o (rot)
  );

  for (genvar j = 0; j < WORD_BYTES; j++) begin : g_gate
    assign wdata_o[j*BYTE_W +: BYTE_W] = be_o[j] ? rot[j*BYTE_W +: BYTE_W] : '0;
  end
endmodule

// File: rtl/ua_store_align_chk.sv
module ua_store_align_chk #(
  parameter int WORD_BYTES = 4,
  parameter int BYTE_W     = 8,
  localparam int OFS_W  = $clog2(WORD_BYTES),
  localparam int DATA_W = WORD_BYTES * BYTE_W
) (
  input logic                  kind_i,
  input logic [OFS_W-1:0]      ofs_i,
  input logic [DATA_W-1:0]     src_i,
  input logic [DATA_W-1:0]     wdata_o,
  input logic [WORD_BYTES-1:0] be_o
);
  always_comb begin
    if (!kind_i) begin
      AST_LEFT_MASK: assert (be_o[0] && be_o[ofs_i] && $countones(be_o) == int'(ofs_i) + 1)
        else $error("left mask"); // R1
      AST_LEFT_TOP_BYTE: assert (wdata_o[ofs_i*BYTE_W +: BYTE_W] == src_i[DATA_W-1 -: BYTE_W])
        else $error("left top byte"); // R3
    end else begin
      AST_RIGHT_MASK: assert (be_o[WORD_BYTES-1] && be_o[ofs_i] && $countones(be_o) == WORD_BYTES - int'(ofs_i))
        else $error("right mask"); // R2
      AST_RIGHT_LOW_BYTE: assert (wdata_o[ofs_i*BYTE_W +: BYTE_W] == src_i[BYTE_W-1:0])
        else $error("right low byte"); // R4
    end
    for (int j = 0; j < WORD_BYTES; j++) begin
      if (!be_o[j]) begin
        AST_IDLE_LANE_ZERO: assert (wdata_o[j*BYTE_W +: BYTE_W] == '0)
          else $error("idle lane nonzero"); // R5
      end
    end
  end
endmodule

bind ua_store_align ua_store_align_chk #(.WORD_BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) i_chk (.*);

// File: tb/test_ua_store_align.sv
module test_ua_store_align;
  logic        clk = 1'b0;
  logic        kind_i;
  logic [1:0]  ofs_i;
  logic [31:0] src_i;
  logic [31:0] wdata_o;
  logic [3:0]  be_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] mem [8];

  always #10 clk = ~clk;

  ua_store_align i_ua_store_align (
    .kind_i  (kind_i),
    .ofs_i   (ofs_i),
    .src_i   (src_i),
    .wdata_o (wdata_o),
    .be_o    (be_o)
  );

  typedef struct packed {
    logic        kind;
    logic [1:0]  ofs;
    logic [31:0] src;
    logic [31:0] exp_data;
    logic [3:0]  exp_be;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 32'hAABBCCDD, 32'h000000AA, 4'b0001},
    '{1'b0, 2'd1, 32'hAABBCCDD, 32'h0000AABB, 4'b0011},
    '{1'b0, 2'd2, 32'hAABBCCDD, 32'h00AABBCC, 4'b0111},
    '{1'b0, 2'd3, 32'hAABBCCDD, 32'hAABBCCDD, 4'b1111},
    '{1'b1, 2'd0, 32'hAABBCCDD, 32'hAABBCCDD, 4'b1111},
    '{1'b1, 2'd1, 32'hAABBCCDD, 32'hBBCCDD00, 4'b1110},
    '{1'b1, 2'd2, 32'hAABBCCDD, 32'hCCDD0000, 4'b1100},
    '{1'b1, 2'd3, 32'hAABBCCDD, 32'hDD000000, 4'b1000},
    '{1'b0, 2'd1, 32'h01234567, 32'h00000123, 4'b0011},
    '{1'b0, 2'd2, 32'h01234567, 32'h00012345, 4'b0111},
    '{1'b1, 2'd1, 32'h01234567, 32'h23456700, 4'b1110},
    '{1'b1, 2'd3, 32'h01234567, 32'h67000000, 4'b1000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic k, input logic [1:0] o, input logic [31:0] s);
    @(negedge clk);
    kind_i = k; ofs_i = o; src_i = s;
    #2;
  endtask

  task automatic mem_store(input logic k, input int addr, input logic [31:0] s);
    apply(k, addr[1:0], s);
    for (int j = 0; j < 4; j++)
      if (be_o[j]) mem[(addr & ~3) + j] = wdata_o[j*8 +: 8];
  endtask

  task automatic mem_fill();
    for (int i = 0; i < 8; i++) mem[i] = 8'(i * 8'h11);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // initial state: left store, offset 0, zero source
    apply(1'b0, 2'd0, 32'h0);
    chk("R1 initial be", {28'h0, be_o}, 32'h1);
    chk("R5 initial data", wdata_o, 32'h0);

    // R1 R2 R3 R4 R6 R7 vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].kind, VEC[i].ofs, VEC[i].src);
      chk(VEC[i].kind ? "R2 R6 be" : "R1 R6 be", {28'h0, be_o}, {28'h0, VEC[i].exp_be});
      chk(VEC[i].kind ? "R4 R5 data" : "R3 R5 data", wdata_o, VEC[i].exp_data);
    end

    // R7: aligned case for both kinds with all-ones pattern
    apply(1'b0, 2'd3, 32'hFFFF_FFFF);
    chk("R7 left full", wdata_o, 32'hFFFF_FFFF);
    apply(1'b1, 2'd0, 32'h8000_0001);
    chk("R7 right full", wdata_o, 32'h8000_0001);

    // R10: change inputs without a clock edge
    kind_i = 1'b1; ofs_i = 2'd2; src_i = 32'h1122_3344;
    #1;
    chk("R10 comb data", wdata_o, 32'h3344_0000);
    kind_i = 1'b0;
    #1;
    chk("R10 comb be", {28'h0, be_o}, 32'h7);

    // R8 R9: unaligned word at address 1
    mem_fill();
    mem_store(1'b1, 1, 32'hAABBCCDD);
    mem_store(1'b0, 4, 32'hAABBCCDD);
    chk("R9 word@1", {mem[4], mem[3], mem[2], mem[1]}, 32'hAABBCCDD);
    chk("R8 keep@1", {mem[0], mem[5], mem[6], mem[7]}, 32'h00556677);

    // R8 R9: unaligned word at address 2
    mem_fill();
    mem_store(1'b1, 2, 32'h0102_0304);
    mem_store(1'b0, 5, 32'h0102_0304);
    chk("R9 word@2", {mem[5], mem[4], mem[3], mem[2]}, 32'h0102_0304);
    chk("R8 keep@2", {mem[0], mem[1], mem[6], mem[7]}, 32'h00116677);

    // R8 R9: unaligned word at address 3
    mem_fill();
    mem_store(1'b1, 3, 32'hCAFE_F00D);
    mem_store(1'b0, 6, 32'hCAFE_F00D);
    chk("R9 word@3", {mem[6], mem[5], mem[4], mem[3]}, 32'hCAFE_F00D);
    chk("R8 keep@3", {mem[0], mem[1], mem[2], mem[7]}, 32'h00112277);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule